// File: doc/BRIEF.md
# Trap Entry and Interrupt-Level Controller

This block decides, every clock cycle, whether the processor takes a trap. It also produces everything the trap entry sequence changes. The inputs are:

- a processor reset request;
- a synchronous trap request carrying an 8-bit type code;
- a 4-bit external interrupt level;
- the current processor state: the trap-enable flag, the supervisor and previous-supervisor flags, the interrupt mask level, the window pointer, the trap base address and the current PC/nPC pair.

When a request wins, the block produces one registered pulse in the next cycle. The pulse carries:

- the new state flags;
- the new window pointer;
- a trap base register value with the trap type inserted;
- a write request that stores PC and nPC in locals 1 and 2 of the new window;
- a fetch redirect.

The surrounding pipeline applies these values. A synchronous trap that arrives while traps are disabled puts the block into a sticky error mode. Only a reset request leaves that mode.

The block keeps no copy of the processor flags; it reads them from its inputs. For that reason it accepts no trap or interrupt in the cycle right after an entry, while those inputs still show the old state.

Top module: `trap_entry_ctrl`

## Requirements
- R1: When `reset_req` is high at a clock edge, then in the following cycle, whatever else is requested and even in error mode:
  - `reset_taken` is 1 and `state_wr` is 1;
  - `new_et`=0, `new_s`=1, and `new_ps` and `new_cwp` repeat `cur_ps` and `cur_cwp`;
  - `redirect`=1 with `redirect_pc`=0 and `redirect_npc`=4;
  - `tbr_wr`=0, `rf_we`=0 and `error_mode`=0;
  - `reset_taken` and `trap_taken` are never high together.
- R2: An interrupt is taken only when `irq_level` is nonzero and greater than `cur_pil`. Level 0 is never taken. Its trap type is 0x10 plus the level.
- R3: Level 15 is taken whatever `cur_pil` is, provided `cur_et`=1. With `cur_et`=0 no interrupt of any level is taken.
- R4: A synchronous request with `cur_et`=1 is taken with type `sync_tt`. It wins over an interrupt pending in the same cycle.
- R5: A synchronous request with `cur_et`=0 takes no trap and sets `error_mode` in the next cycle. While `error_mode` is 1, every trap and interrupt request is ignored, and it stays 1 until a reset request.
- R6: On a trap entry, `state_wr`=1, `new_et`=0, `new_s`=1 and `new_ps`=`cur_s`. `new_cwp` is `cur_cwp` minus one, modulo the window count (0 wraps to 7 with 8 windows).
- R7: On a trap entry, `rf_we`=1 and `rf_win`=`new_cwp`. `rf_l1_data` is `cur_pc` (local register 1) and `rf_l2_data` is `cur_npc` (local register 2).
- R8: On a trap entry, `tbr_wr`=1 and `new_tbr` has the following layout:
  - bits 31:12 are `cur_tba`;
  - bits 11:4 are the trap type;
  - bits 3:0 are zero.
- R9: On a trap entry, `redirect`=1, `redirect_pc`=`new_tbr` and `redirect_npc`=`new_tbr`+4.
- R10: The results of inputs sampled at one edge are visible for exactly one cycle after that edge, and all pulse outputs and data fields are 0 otherwise. In the cycle that follows a trap or reset entry, only a reset request is accepted.
- R11: While `rst_n` is low, every output is 0, including `error_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| reset_req | input | 1 | Processor reset request |
| sync_req | input | 1 | Synchronous trap request |
| sync_tt | input | 8 | Trap type of the synchronous request |
| irq_level | input | 4 | External interrupt level, 0 = none |
| cur_et | input | 1 | Current trap-enable flag |
| cur_s | input | 1 | Current supervisor flag |
| cur_ps | input | 1 | Current previous-supervisor flag |
| cur_pil | input | 4 | Current interrupt mask level |
| cur_cwp | input | 3 | Current window pointer |
| cur_tba | input | 20 | Trap base address field of the trap base register |
| cur_pc | input | 32 | Current PC |
| cur_npc | input | 32 | Current nPC |
| trap_taken | output | 1 | Trap or interrupt entry pulse |
| reset_taken | output | 1 | Reset entry pulse |
| error_mode | output | 1 | Sticky error mode |
| state_wr | output | 1 | Write the new state flags |
| new_et | output | 1 | New trap-enable flag |
| new_s | output | 1 | New supervisor flag |
| new_ps | output | 1 | New previous-supervisor flag |
| new_cwp | output | 3 | New window pointer |
| tbr_wr | output | 1 | Write the trap base register |
| new_tbr | output | 32 | New trap base register value |
| rf_we | output | 1 | Register file write of the saved PC pair |
| rf_win | output | 3 | Window receiving the saved PC pair |
| rf_l1_data | output | 32 | Value for local register 1 (PC) |
| rf_l2_data | output | 32 | Value for local register 2 (nPC) |
| redirect | output | 1 | Fetch redirect pulse |
| redirect_pc | output | 32 | New PC |
| redirect_npc | output | 32 | New nPC |

## Verification
Every result is computed from the inputs present at one rising edge and appears in the single cycle after it. `error_mode` is the exception: it is a level that persists until a reset request.

The bench changes inputs on falling edges. For each stimulus it queues one expected output set. A monitor compares that set 1 ns after the next rising edge, so each expectation is checked in exactly the cycle it is due.

The blocked cycle after an entry is covered by holding a request one cycle longer and expecting an all-quiet result. The sticky error mode is covered by a sequence of ignored requests, each followed by a check that the outputs stayed quiet.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;

    localparam int TT_W        = 8;
    localparam int LVL_W       = 4;
    localparam int TT_LSB      = 4;
    localparam int BASE_LSB    = TT_LSB + TT_W;
    localparam logic [LVL_W-1:0] LVL_TOP     = '1;
    localparam logic [TT_W-1:0]  IRQ_TT_BASE = 8'h10;
    localparam int NPC_STEP    = 4;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_RESET,
        ACT_SYNC,
        ACT_IRQ,
        ACT_FAULT
    } act_e;

endpackage

// File: rtl/trap_arbiter.sv
module trap_arbiter
    import trap_ctrl_pkg::*;
(
    input  logic             reset_req,
    input  logic             sync_req,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             cur_et,
    input  logic [LVL_W-1:0] cur_pil,
    input  logic             blocked,
    input  logic             halted,
    output act_e             act
);

    logic irq_ok;

    always_comb begin
        irq_ok = cur_et && (irq_level != '0) &&
                 ((irq_level == LVL_TOP) || (irq_level > cur_pil));
        if (reset_req)
            act = ACT_RESET;
        else if (halted || blocked)
            act = ACT_IDLE;
        else if (sync_req)
            act = cur_et ? ACT_SYNC : ACT_FAULT;
        else if (irq_ok)
            act = ACT_IRQ;
        else
            act = ACT_IDLE;
    end

endmodule

// File: rtl/trap_frame_gen.sv
module trap_frame_gen
    import trap_ctrl_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NWIN  = 8,
    parameter int CWP_W = $clog2(NWIN)
) (
    input  act_e                   act,
    input  logic [TT_W-1:0]        tt,
    input  logic                   cur_s,
    input  logic                   cur_ps,
    input  logic [CWP_W-1:0]       cur_cwp,
    input  logic [XLEN-1:BASE_LSB] cur_tba,
    input  logic [XLEN-1:0]        cur_pc,
    input  logic [XLEN-1:0]        cur_npc,
    output logic                   take,
    output logic                   rst_take,
    output logic                   st_we,
    output logic                   nxt_et,
    output logic                   nxt_s,
    output logic                   nxt_ps,
    output logic [CWP_W-1:0]       nxt_cwp,
    output logic                   tbr_we,
    output logic [XLEN-1:0]        nxt_tbr,
    output logic                   rf_we,
    output logic [CWP_W-1:0]       rf_win,
    output logic [XLEN-1:0]        l1_data,
    output logic [XLEN-1:0]        l2_data,
    output logic                   redir,
    output logic [XLEN-1:0]        redir_pc,
    output logic [XLEN-1:0]        redir_npc
);

    localparam logic [CWP_W-1:0] CWP_LAST = CWP_W'(NWIN - 1);

    logic [CWP_W-1:0] cwp_dec;
    logic [XLEN-1:0]  tbr_val;

    generate
        if ((NWIN & (NWIN - 1)) == 0) begin : g_pow2_wrap
            assign cwp_dec = cur_cwp - 1'b1;
        end else begin : g_cmp_wrap
            assign cwp_dec = (cur_cwp == '0) ? CWP_LAST : cur_cwp - 1'b1;
        end
    endgenerate

    assign tbr_val = {cur_tba, tt, {TT_LSB{1'b0}}};

    always_comb begin
        take      = 1'b0;
        rst_take  = 1'b0;
        st_we     = 1'b0;
        nxt_et    = 1'b0;
        nxt_s     = 1'b0;
        nxt_ps    = 1'b0;
        nxt_cwp   = '0;
        tbr_we    = 1'b0;
        nxt_tbr   = '0;
        rf_we     = 1'b0;
        rf_win    = '0;
        l1_data   = '0;
        l2_data   = '0;
        redir     = 1'b0;
        redir_pc  = '0;
        redir_npc = '0;
        case (act)
            ACT_RESET: begin
                rst_take  = 1'b1;
                st_we     = 1'b1;
                nxt_et    = 1'b0;
                nxt_s     = 1'b1;
                nxt_ps    = cur_ps;
                nxt_cwp   = cur_cwp;
                redir     = 1'b1;
                redir_pc  = '0;
                redir_npc = XLEN'(NPC_STEP);
            end
            ACT_SYNC, ACT_IRQ: begin
                take      = 1'b1;
                st_we     = 1'b1;
                nxt_et    = 1'b0;
                nxt_s     = 1'b1;
                nxt_ps    = cur_s;
                nxt_cwp   = cwp_dec;
                tbr_we    = 1'b1;
                nxt_tbr   = tbr_val;
                rf_we     = 1'b1;
                rf_win    = cwp_dec;
                l1_data   = cur_pc;
                l2_data   = cur_npc;
                redir     = 1'b1;
                redir_pc  = tbr_val;
                redir_npc = tbr_val + XLEN'(NPC_STEP);
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
    import trap_ctrl_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NWIN  = 8,
    localparam int CWP_W = $clog2(NWIN)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reset_req,
    input  logic                   sync_req,
    input  logic [TT_W-1:0]        sync_tt,
    input  logic [LVL_W-1:0]       irq_level,
    input  logic                   cur_et,
    input  logic                   cur_s,
    input  logic                   cur_ps,
    input  logic [LVL_W-1:0]       cur_pil,
    input  logic [CWP_W-1:0]       cur_cwp,
    input  logic [XLEN-1:BASE_LSB] cur_tba,
    input  logic [XLEN-1:0]        cur_pc,
    input  logic [XLEN-1:0]        cur_npc,
    output logic                   trap_taken,
    output logic                   reset_taken,
    output logic                   error_mode,
    output logic                   state_wr,
    output logic                   new_et,
    output logic                   new_s,
    output logic                   new_ps,
    output logic [CWP_W-1:0]       new_cwp,
    output logic                   tbr_wr,
    output logic [XLEN-1:0]        new_tbr,
    output logic                   rf_we,
    output logic [CWP_W-1:0]       rf_win,
    output logic [XLEN-1:0]        rf_l1_data,
    output logic [XLEN-1:0]        rf_l2_data,
    output logic                   redirect,
    output logic [XLEN-1:0]        redirect_pc,
    output logic [XLEN-1:0]        redirect_npc
);

    typedef struct packed {
        logic             trap;
        logic             rst;
        logic             err;
        logic             blk;
        logic             st_we;
        logic             et;
        logic             s;
        logic             ps;
        logic [CWP_W-1:0] cwp;
        logic             tbr_we;
        logic [XLEN-1:0]  tbr;
        logic             rf_we;
        logic [CWP_W-1:0] win;
        logic [XLEN-1:0]  l1;
        logic [XLEN-1:0]  l2;
        logic             redir;
        logic [XLEN-1:0]  pc;
        logic [XLEN-1:0]  npc;
    } regs_t;

    regs_t           regs_d, regs_q;
    act_e            act;
    logic [TT_W-1:0] tt_sel;

    logic             f_take, f_rst, f_st_we, f_et, f_s, f_ps, f_tbr_we, f_rf_we, f_redir;
    logic [CWP_W-1:0] f_cwp, f_win;
    logic [XLEN-1:0]  f_tbr, f_l1, f_l2, f_pc, f_npc;

    trap_arbiter u_arb (
        .reset_req (reset_req),
        .sync_req  (sync_req),
        .irq_level (irq_level),
        .cur_et    (cur_et),
        .cur_pil   (cur_pil),
        .blocked   (regs_q.blk),
        .halted    (regs_q.err),
        .act       (act)
    );

    always_comb begin
        if (act == ACT_SYNC)
            tt_sel = sync_tt;
        else
            tt_sel = IRQ_TT_BASE + TT_W'(irq_level);
    end

    trap_frame_gen #(
        .XLEN  (XLEN),
        .NWIN  (NWIN),
        .CWP_W (CWP_W)
    ) u_frame (
        .act       (act),
        .tt        (tt_sel),
        .cur_s     (cur_s),
        .cur_ps    (cur_ps),
        .cur_cwp   (cur_cwp),
        .cur_tba   (cur_tba),
        .cur_pc    (cur_pc),
        .cur_npc   (cur_npc),
        .take      (f_take),
        .rst_take  (f_rst),
        .st_we     (f_st_we),
        .nxt_et    (f_et),
        .nxt_s     (f_s),
        .nxt_ps    (f_ps),
        .nxt_cwp   (f_cwp),
        .tbr_we    (f_tbr_we),
        .nxt_tbr   (f_tbr),
        .rf_we     (f_rf_we),
        .rf_win    (f_win),
        .l1_data   (f_l1),
        .l2_data   (f_l2),
        .redir     (f_redir),
        .redir_pc  (f_pc),
        .redir_npc (f_npc)
    );

    always_comb begin
        regs_d        = '0;
        regs_d.trap   = f_take;
        regs_d.rst    = f_rst;
        regs_d.blk    = f_take | f_rst;
        regs_d.st_we  = f_st_we;
        regs_d.et     = f_et;
        regs_d.s      = f_s;
        regs_d.ps     = f_ps;
        regs_d.cwp    = f_cwp;
        regs_d.tbr_we = f_tbr_we;
        regs_d.tbr    = f_tbr;
        regs_d.rf_we  = f_rf_we;
        regs_d.win    = f_win;
        regs_d.l1     = f_l1;
        regs_d.l2     = f_l2;
        regs_d.redir  = f_redir;
        regs_d.pc     = f_pc;
        regs_d.npc    = f_npc;
        case (act)
            ACT_RESET: regs_d.err = 1'b0;
            ACT_FAULT: regs_d.err = 1'b1;
            default:   regs_d.err = regs_q.err;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            regs_q <= '0;
        else
            regs_q <= regs_d;
    end

    assign trap_taken   = regs_q.trap;
    assign reset_taken  = regs_q.rst;
    assign error_mode   = regs_q.err;
    assign state_wr     = regs_q.st_we;
    assign new_et       = regs_q.et;
    assign new_s        = regs_q.s;
    assign new_ps       = regs_q.ps;
    assign new_cwp      = regs_q.cwp;
    assign tbr_wr       = regs_q.tbr_we;
    assign new_tbr      = regs_q.tbr;
    assign rf_we        = regs_q.rf_we;
    assign rf_win       = regs_q.win;
    assign rf_l1_data   = regs_q.l1;
    assign rf_l2_data   = regs_q.l2;
    assign redirect     = regs_q.redir;
    assign redirect_pc  = regs_q.pc;
    assign redirect_npc = regs_q.npc;

    // R1: reset entry and trap entry never share a cycle
    a_r1_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({trap_taken, reset_taken}));

    // R2: an interrupt at or below the mask, not level 15, is never taken
    a_r2_masked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!reset_req && !sync_req && irq_level != LVL_TOP && irq_level <= cur_pil)
        |-> !trap_taken);

    // R3: with traps disabled nothing is taken
    a_r3_et_gates: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!cur_et && !reset_req) |-> !trap_taken);

    // R5: error mode holds until a reset request
    a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        $past(error_mode) && !$past(reset_req) |-> error_mode);

    // R6: entry clears trap enable and saves the supervisor flag
    a_r6_entry_flags: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (state_wr && !new_et && new_s && new_ps == $past(cur_s)));

    // R9: the redirected nPC follows the redirected PC by one word
    a_r9_npc_step: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (redirect_npc == redirect_pc + XLEN'(NPC_STEP)));

    // R10: no trap in the cycle after an entry unless reset is requested
    a_r10_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        $past(trap_taken || reset_taken) |-> !trap_taken);

endmodule

// File: tb/trap_entry_ctrl_tb.sv
`timescale 1ns/1ps
module trap_entry_ctrl_tb;

    localparam int NWIN = 8;
    localparam int CW   = 3;

    typedef struct packed {
        logic          trap;
        logic          rst;
        logic          err;
        logic          st_we;
        logic          et;
        logic          s;
        logic          ps;
        logic [CW-1:0] cwp;
        logic          tbr_we;
        logic [31:0]   tbr;
        logic          rf_we;
        logic [CW-1:0] win;
        logic [31:0]   l1;
        logic [31:0]   l2;
        logic          redir;
        logic [31:0]   pc;
        logic [31:0]   npc;
    } obs_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reset_req = 0, sync_req = 0, cur_et = 0, cur_s = 0, cur_ps = 0;
    logic [7:0]  sync_tt = 0;
    logic [3:0]  irq_level = 0, cur_pil = 0;
    logic [CW-1:0] cur_cwp = 0;
    logic [19:0] cur_tba = 0;
    logic [31:0] cur_pc = 0, cur_npc = 0;

    logic trap_taken, reset_taken, error_mode, state_wr, new_et, new_s, new_ps;
    logic tbr_wr, rf_we, redirect;
    logic [CW-1:0] new_cwp, rf_win;
    logic [31:0] new_tbr, rf_l1_data, rf_l2_data, redirect_pc, redirect_npc;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit m_err = 0;
    bit m_blk = 0;

    obs_t  exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    trap_entry_ctrl #(.XLEN(32), .NWIN(NWIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .sync_req(sync_req),
        .sync_tt(sync_tt), .irq_level(irq_level), .cur_et(cur_et), .cur_s(cur_s),
        .cur_ps(cur_ps), .cur_pil(cur_pil), .cur_cwp(cur_cwp), .cur_tba(cur_tba),
        .cur_pc(cur_pc), .cur_npc(cur_npc), .trap_taken(trap_taken),
        .reset_taken(reset_taken), .error_mode(error_mode), .state_wr(state_wr),
        .new_et(new_et), .new_s(new_s), .new_ps(new_ps), .new_cwp(new_cwp),
        .tbr_wr(tbr_wr), .new_tbr(new_tbr), .rf_we(rf_we), .rf_win(rf_win),
        .rf_l1_data(rf_l1_data), .rf_l2_data(rf_l2_data), .redirect(redirect),
        .redirect_pc(redirect_pc), .redirect_npc(redirect_npc)
    );

    function automatic obs_t actual();
        obs_t a;
        a = '{trap_taken, reset_taken, error_mode, state_wr, new_et, new_s, new_ps,
              new_cwp, tbr_wr, new_tbr, rf_we, rf_win, rf_l1_data, rf_l2_data,
              redirect, redirect_pc, redirect_npc};
        return a;
    endfunction

    // Expected result from the requirements for the current inputs
    task automatic step(input string tag);
        obs_t e;
        bit irq_ok, take;
        logic [7:0] tt;
        logic [31:0] tbr;
        e = '0;
        irq_ok = cur_et && irq_level != 0 && (irq_level == 4'hF || irq_level > cur_pil);
        take = 0;
        e.err = m_err;
        if (reset_req) begin                              // R1
            e.rst = 1; e.st_we = 1; e.et = 0; e.s = 1; e.ps = cur_ps;
            e.cwp = cur_cwp; e.redir = 1; e.pc = 0; e.npc = 4; e.err = 0;
        end else if (!m_err && !m_blk) begin
            if (sync_req && !cur_et) e.err = 1;           // R5
            else if (sync_req) begin take = 1; tt = sync_tt; end          // R4
            else if (irq_ok) begin take = 1; tt = 8'h10 + {4'h0, irq_level}; end // R2 R3
        end
        if (take) begin                                   // R6 R7 R8 R9
            tbr = {cur_tba, tt, 4'h0};
            e.trap = 1; e.st_we = 1; e.et = 0; e.s = 1; e.ps = cur_s;
            e.cwp = (cur_cwp == 0) ? CW'(NWIN - 1) : cur_cwp - 1'b1;
            e.tbr_we = 1; e.tbr = tbr; e.rf_we = 1; e.win = e.cwp;
            e.l1 = cur_pc; e.l2 = cur_npc; e.redir = 1; e.pc = tbr; e.npc = tbr + 4;
        end
        m_err = e.err;
        m_blk = e.trap | e.rst;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
    endtask

    // Monitor: compare one expectation 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            obs_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (actual() !== e) begin
                errors++;
                $display("FAIL %s: actual %h expected %h", t, actual(), e);
            end
        end
    end

    task automatic check_quiet(input string tag);
        checks++;
        if (actual() !== '0) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, actual(), obs_t'(0));
        end
    endtask

    task automatic idle_in();
        reset_req = 0; sync_req = 0; irq_level = 0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cur_tba = 20'hABCDE; cur_pc = 32'h0000_1000; cur_npc = 32'h0000_1004;
        #1 check_quiet("R11 reset state");
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        step("R10 idle quiet");
        // R2 interrupt above mask, R6 window wrap 0 -> 7
        cur_et = 1; cur_s = 0; cur_pil = 3; cur_cwp = 0; irq_level = 5;
        step("R2 irq 5 over pil 3");
        step("R10 blocked cycle after entry");
        cur_cwp = 7; irq_level = 3;
        step("R2 irq equal to mask ignored");
        irq_level = 0; cur_pil = 0;
        step("R2 level 0 ignored");
        // R3 level 15 ignores mask
        irq_level = 15; cur_pil = 15; cur_s = 1; cur_cwp = 3; cur_tba = 20'h12345;
        step("R3 level 15 over pil 15");
        idle_in(); step("R10 gap");
        cur_et = 0; irq_level = 15;
        step("R3 level 15 with traps disabled");
        // R4 sync wins over irq, R7 saved PC pair
        cur_et = 1; cur_s = 0; cur_cwp = 5; irq_level = 7; cur_pil = 0;
        sync_req = 1; sync_tt = 8'h09; cur_pc = 32'h4000_0020; cur_npc = 32'h4000_0024;
        step("R4 sync beats irq");
        idle_in(); step("R10 gap");
        // R11 asynchronous reset mid-run
        cur_et = 1; irq_level = 9; cur_pil = 2;
        step("R2 irq 9 before async reset");
        idle_in();
        rst_n = 0; m_err = 0; m_blk = 0;
        #1 check_quiet("R11 async reset clears outputs");
        @(negedge clk); rst_n = 1; @(negedge clk);
        // R5 sync with traps disabled -> error mode
        cur_et = 0; sync_req = 1; sync_tt = 8'h02;
        step("R5 sync with et 0");
        sync_req = 0; cur_et = 1; irq_level = 15;
        step("R5 irq ignored in error mode");
        irq_level = 0; sync_req = 1;
        step("R5 sync ignored in error mode");
        // R1 reset wins and clears error mode
        reset_req = 1; sync_req = 1; irq_level = 15; cur_ps = 1; cur_cwp = 6;
        step("R1 reset over sync and irq");
        reset_req = 0;
        step("R10 blocked after reset entry");
        sync_req = 0; irq_level = 4; cur_pil = 1; cur_s = 1; cur_cwp = 1; cur_tba = 20'hFFFFF;
        step("R8 irq tt and tbr layout after reset");
        idle_in();
        step("R9 quiet after entry");
        step("R10 idle");
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule